// File: doc/BRIEF.md
# Cascaded Decade Event Counter

A multi-digit BCD event counter built from identical digit stages on one clock. Each stage holds one BCD digit. Each stage advances when its enable input is high, and it drives a carry-enable out to the next stage up. The carry chain replaces the rippled clocks of a discrete counter, so every digit changes on the same edge. In decimal mode the three stages count events from 000 to 999 and then wrap. In this mode the terminal pulse divides the event rate by 1000.

A second mode pairs a units stage that wraps after 9 with a tens stage that wraps after 5. The hundreds digit is held at zero. The block then counts 00 to 59 and its terminal pulse divides the event rate by 60. The mode is captured only on a synchronous clear, so a running count never changes modulus midway. The block leaves display decoding to downstream logic.

Top module: `bcd_chain`

## Requirements
- R1: While rst_ni is low, count_o reads zero and tc_o is low, and the block comes out of reset in decimal mode whatever mode_i holds.
- R2: The units digit (count_o[3:0]) takes one step per clock edge at which evt_i is high, goes from 0 to 9 in decimal mode, and returns to 0 on the event after 9.
- R3: A higher digit steps only on an edge where evt_i is high and every lower digit sits at its maximum. With evt_i low, count_o holds.
- R4: In decimal mode count_o is BCD with hundreds in [11:8], tens in [7:4] and units in [3:0]. The carries give 009→010, 099→100 and 999→000.
- R5: tc_o is high for exactly one cycle, the cycle in which count_o first shows the wrapped value. That makes one pulse per 1000 events in decimal mode.
- R6: In mod-60 mode (mode_i=1 at the last clear), units wrap after 9, tens wrap after 5 and hundreds stay 0. 059→000 raises tc_o, and this gives one pulse per 60 events.
- R7: mode_i is sampled only on an edge where clr_i is high. Changing it at any other time leaves the counting modulus unchanged.
- R8: clr_i is a synchronous clear. It takes priority over evt_i and gives count_o=0 and tc_o low after the edge.
- R9: No digit ever shows a value above the maximum of its stage in the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear; also loads mode_i |
| evt_i | input | 1 | Event enable, one count per high cycle |
| mode_i | input | 1 | 0 = decimal 000-999, 1 = divide-by-60 |
| count_o | output | 12 | BCD digits, hundreds/tens/units from MSB |
| tc_o | output | 1 | One-cycle terminal-count pulse |

## Verification
Any wrong state in a digit shows up on count_o at the next event-enabled edge that touches that stage. A digit that holds a bad value, or misses its wrap, shows up within one step. A broken carry only shows when the lower digits reach their maximum, so the stimulus walks across each digit boundary (9→10, 99→100, 999→000, 59→00). A stale or wrongly latched mode register shows up only as a wrong modulus. It is exposed by counting past 59 before and after a clear and by counting tc_o pulses over whole cycles.

// File: rtl/bcd_chain_pkg.sv
package bcd_chain_pkg;
  typedef enum logic {
    MODE_DEC   = 1'b0,
    MODE_SIX10 = 1'b1
  } chain_mode_e;

  // wrap value of digit stage idx for the given mode
  function automatic int unsigned stage_max(chain_mode_e m, int unsigned idx);
    if (m == MODE_DEC) return 9;
    if (idx == 0) return 9;
    if (idx == 1) return 5;
    return 0;
  endfunction
endpackage

// File: rtl/bcd_mode_ctrl.sv
module bcd_mode_ctrl
  import bcd_chain_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3,
  parameter int unsigned DIGIT_W    = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clr_i,
  input  logic                             mode_i,
  output chain_mode_e                      mode_o,
  output logic [NUM_DIGITS*DIGIT_W-1:0]    max_o
);
  chain_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MODE_DEC;
    else if (clr_i) mode_q <= chain_mode_e'(mode_i);
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_max
    assign max_o[g*DIGIT_W +: DIGIT_W] = DIGIT_W'(stage_max(mode_q, g));
  end

  assign mode_o = mode_q;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> $stable(mode_q)); // R7
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage #(
  parameter int unsigned DIGIT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [DIGIT_W-1:0] max_i,
  output logic [DIGIT_W-1:0] cnt_o,
  output logic               carry_o
);
  logic [DIGIT_W-1:0] cnt_q;
  logic               at_max;

  // >= rather than == so an out-of-range value can never persist
  assign at_max = (cnt_q >= max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= at_max ? '0 : cnt_q + 1'b1;
  end

  assign carry_o = en_i & at_max;
  assign cnt_o   = cnt_q;

  AST_DIGIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= max_i); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && cnt_q == max_i) |=> cnt_q == '0); // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && cnt_q < max_i) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
  import bcd_chain_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3,
  parameter int unsigned DIGIT_W    = 4,
  localparam int unsigned CNT_W     = NUM_DIGITS * DIGIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             evt_i,
  input  logic             mode_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);
  chain_mode_e          mode;
  logic [CNT_W-1:0]     max_vec;
  logic [NUM_DIGITS:0]  carry;
  logic                 tc_q;

  bcd_mode_ctrl #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .mode_i (mode_i),
    .mode_o (mode),
    .max_o  (max_vec)
  );

  assign carry[0] = evt_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_stage
    bcd_digit_stage #(.DIGIT_W(DIGIT_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_i),
      .en_i    (carry[g]),
      .max_i   (max_vec[g*DIGIT_W +: DIGIT_W]),
      .cnt_o   (count_o[g*DIGIT_W +: DIGIT_W]),
      .carry_o (carry[g+1])
    );
  end

  // top carry marks the all-max -> all-zero event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tc_q <= 1'b0;
    else if (clr_i) tc_q <= 1'b0;
    else            tc_q <= carry[NUM_DIGITS];
  end

  assign tc_o = tc_q;

  AST_TC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o); // R5
  AST_TC_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> count_o == '0); // R5
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0 && !tc_o)); // R8
  AST_SIX10_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_SIX10 |-> count_o[CNT_W-1:2*DIGIT_W] == '0); // R6
endmodule

// File: tb/bcd_chain_bench.sv
module bcd_chain_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        evt_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [11:0] count_o;
  logic        tc_o;

  int checks = 0;
  int fails  = 0;
  int tc_seen;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  bcd_chain u_bcd_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .evt_i(evt_i), .mode_i(mode_i), .count_o(count_o), .tc_o(tc_o)
  );

  // table: events to apply, expected decimal value, expected tc after last
  localparam int NV = 8;
  localparam int V_N  [NV] = '{1, 8, 1, 89, 1, 899, 1, 5};
  localparam int V_EXP[NV] = '{1, 9, 10, 99, 100, 999, 0, 5};
  localparam bit V_TC [NV] = '{0, 0, 0, 0, 0, 0, 1, 0};

  function automatic logic [11:0] to_bcd(int v);
    return {4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock with evt driven; sample after the edge
  task automatic step(bit e);
    @(negedge clk_i);
    evt_i = e;
    @(posedge clk_i);
    #1;
    if (tc_o) tc_seen++;
    evt_i = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  task automatic do_clr(bit m, bit e);
    @(negedge clk_i);
    clr_i = 1'b1; mode_i = m; evt_i = e;
    @(posedge clk_i);
    #1;
    clr_i = 1'b0; evt_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mode_i = 1'b1;
    #1;
    check(count_o == 12'h000, "R1 reset count", count_o, 0);
    check(tc_o == 1'b0, "R1 reset tc", tc_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: mode_i=1 during reset must not select mod-60
    tc_seen = 0;
    run(60);
    check(count_o == to_bcd(60), "R1 decimal after reset", count_o, to_bcd(60));
    mode_i = 1'b0;
    do_clr(1'b0, 1'b0);

    // R2 R4 R5 table walk
    for (int k = 0; k < NV; k++) begin
      run(V_N[k]);
      check(count_o == to_bcd(V_EXP[k]), "R4 table value", count_o, to_bcd(V_EXP[k]));
      check(tc_o == V_TC[k], "R5 table tc", tc_o, V_TC[k]);
    end

    // R3: idle holds
    for (int i = 0; i < 3; i++) step(1'b0);
    check(count_o == to_bcd(5), "R3 hold with evt low", count_o, to_bcd(5));
    check(tc_o == 1'b0, "R5 tc low while idle", tc_o, 0);

    // R3: tens waits for units at 9
    run(4);
    check(count_o == to_bcd(9), "R3 tens not stepped", count_o, to_bcd(9));

    // R7: mode change without clear ignored
    mode_i = 1'b1;
    tc_seen = 0;
    run(51);
    check(count_o == to_bcd(60), "R7 mode ignored", count_o, to_bcd(60));
    check(tc_seen == 0, "R7 no tc", tc_seen, 0);

    // R8: clear beats event, loads mode 1
    do_clr(1'b1, 1'b1);
    check(count_o == 12'h000, "R8 clear count", count_o, 0);
    check(tc_o == 1'b0, "R8 clear tc", tc_o, 0);

    // R6 mod-60
    mode_i = 1'b0;
    tc_seen = 0;
    run(9);
    check(count_o == to_bcd(9), "R6 units at 9", count_o, to_bcd(9));
    run(1);
    check(count_o == to_bcd(10), "R6 carry into tens", count_o, to_bcd(10));
    run(49);
    check(count_o == to_bcd(59), "R6 at 59", count_o, to_bcd(59));
    run(1);
    check(count_o == 12'h000, "R6 59 wraps", count_o, 0);
    check(tc_o == 1'b1, "R6 tc at wrap", tc_o, 1);
    step(1'b0);
    check(tc_o == 1'b0, "R5 tc one cycle", tc_o, 0);
    tc_seen = 0;
    run(120);
    check(tc_seen == 2, "R6 divide by 60", tc_seen, 2);

    // R9: scan every count in mod-60 for range
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 60; i++) begin
        step(1'b1);
        if (count_o[11:8] != 0 || count_o[7:4] > 5 || count_o[3:0] > 9) ok = 1'b0;
      end
      check(ok, "R9 mod-60 digit range", count_o, 0);
    end

    // R5: divide by 1000 in decimal
    do_clr(1'b0, 1'b0);
    tc_seen = 0;
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 1000; i++) begin
        step(1'b1);
        if (count_o[11:8] > 9 || count_o[7:4] > 9 || count_o[3:0] > 9) ok = 1'b0;
      end
      check(ok, "R9 decimal digit range", count_o, 0);
    end
    check(tc_seen == 1, "R5 divide by 1000", tc_seen, 1);
    check(count_o == 12'h000, "R4 full cycle back to 000", count_o, 0);

    // R1: async reset mid-count
    run(7);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(count_o == 12'h000, "R1 async reset", count_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule